// File: doc/BRIEF.md
# Audio Delay Effects Processor

This block turns a stream of 12-bit signed audio samples into one of four delay-based effects. The samples come in on a fast system clock, and a one-cycle strobe marks each new one. Every strobed sample is written into a 4096-entry memory at a write pointer. The pointer steps by one per sample and wraps. Three read taps fetch older samples at set distances behind that pointer. The echo tap sits at a fixed distance. The chorus tap sweeps slowly over a long range. A third tap sweeps over a shorter range and feeds both the flanger and the phaser.

Each effect mixes the current sample with half of a delayed sample. Echo, chorus and flanger add the two, and the phaser subtracts. Every result is clamped to the 12-bit signed range. A 2-bit select picks which effect is placed on the registered output. Nothing in the datapath moves between strobes, so the output holds its last value until the next result arrives.

Top module: `audio_fx_delay`

## Requirements
- R1: While rst_ni is low, sample_o is 0 and valid_o is 0. After reset the write pointer and the sweep prescaler are at 0, and both swept delays are at 1 and rising. The buffer contents are not cleared.
- R2: For a strobe sampled on clock edge E, valid_o is high for exactly the one cycle after edge E+1, and valid_o is never high otherwise. Strobes may arrive on back-to-back cycles.
- R3: While valid_o is low, sample_o keeps the value it last took.
- R4: The buffer holds 4096 samples. A tap with delay d returns the sample strobed d strobes before the current one, and this still holds after the write pointer has wrapped past 4096.
- R5: Select 0 (echo) gives sat(x + (y >>> 1)), where y is the sample 2048 strobes back.
- R6: Select 1 (chorus) gives sat(x + (y >>> 1)), where y is taken at the chorus delay, which sweeps between 1 and 801.
- R7: Select 2 (flanger) gives sat(x + (y >>> 1)), where y is taken at the flanger delay, which sweeps between 1 and 400.
- R8: Select 3 (phaser) gives sat(x - (y >>> 1)), using the same tap as the flanger.
- R9: Both swept delays move by one step on every 16th strobe, counting from reset. A rising delay that is at its maximum turns and steps down. A falling delay that is at 1 turns and steps up. Each strobe uses the delay value in force before that strobe's own update.
- R10: Every sum or difference is clamped to the range -2048 to 2047.
- R11: The select is sampled only with the strobe. Changing it between strobes has no effect on the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| strobe_i | input | 1 | One-cycle pulse that marks a new audio sample |
| sample_i | input | 12 | Signed input sample, taken when strobe_i is high |
| sel_i | input | 2 | Effect select: 0 echo, 1 chorus, 2 flanger, 3 phaser |
| sample_o | output | 12 | Signed processed sample, registered |
| valid_o | output | 1 | One-cycle flag that a new sample_o is present |

## Verification
A strobe sampled on one rising edge is captured by the memory read and the first stage on that edge. The output register loads on the next edge, so the result is due at the falling edge one cycle after the strobe's cycle. The bench keeps its own two-stage pipeline of the strobes it drove and compares valid_o with that pipeline at every falling edge. When valid_o is high, it pops the expected value that the driver queued for that strobe, in strobe order. When valid_o is low, it checks that sample_o still holds the last popped value. Expected samples that would reach into buffer slots not yet written are queued as don't-care, so only defined history is compared.

// File: rtl/audio_fx_pkg.sv
package audio_fx_pkg;

  typedef enum logic [1:0] {
    FX_ECHO   = 2'd0,
    FX_CHORUS = 2'd1,
    FX_FLANGE = 2'd2,
    FX_PHASE  = 2'd3
  } fx_sel_e;

  // read taps: 0 echo, 1 chorus, 2 flanger/phaser
  localparam int unsigned FX_TAPS = 3;
  localparam int unsigned FX_NUM  = 4;

  function automatic int unsigned fx_tap(input int unsigned fx);
    case (fx)
      0:       return 0;
      1:       return 1;
      default: return 2;
    endcase
  endfunction

endpackage

// File: rtl/delay_ram.sv
module delay_ram #(
  parameter int unsigned DATA_W = 12,
  parameter int unsigned DEPTH  = 4096,
  parameter int unsigned N_RD   = 3,
  localparam int unsigned ADDR_W = $clog2(DEPTH)
) (
  input  logic                             clk_i,
  input  logic                             wr_en_i,
  input  logic [ADDR_W-1:0]                wr_addr_i,
  input  logic [DATA_W-1:0]                wr_data_i,
  input  logic                             rd_en_i,
  input  logic [N_RD-1:0][ADDR_W-1:0]      rd_addr_i,
  output logic [N_RD-1:0][DATA_W-1:0]      rd_data_o
);

  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (wr_en_i) mem_q[wr_addr_i] <= wr_data_i;
  end

  for (genvar r = 0; r < N_RD; r++) begin : g_rd
    always_ff @(posedge clk_i) begin
      if (rd_en_i) rd_data_o[r] <= mem_q[rd_addr_i[r]];
    end
  end

endmodule

// File: rtl/sweep_gen.sv
module sweep_gen #(
  parameter int unsigned D_W   = 12,
  parameter int unsigned MIN_D = 1,
  parameter int unsigned MAX_D = 400
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           step_i,
  output logic [D_W-1:0] delay_o
);

  localparam logic [D_W-1:0] LO = D_W'(MIN_D);
  localparam logic [D_W-1:0] HI = D_W'(MAX_D);

  logic [D_W-1:0] delay_q;
  logic           up_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      delay_q <= LO;
      up_q    <= 1'b1;
    end else if (step_i) begin
      if (up_q) begin
        if (delay_q == HI) begin
          up_q    <= 1'b0;
          delay_q <= delay_q - 1'b1;
        end else begin
          delay_q <= delay_q + 1'b1;
        end
      end else begin
        if (delay_q == LO) begin
          up_q    <= 1'b1;
          delay_q <= delay_q + 1'b1;
        end else begin
          delay_q <= delay_q - 1'b1;
        end
      end
    end
  end

  assign delay_o = delay_q;

endmodule

// File: rtl/fx_mix.sv
module fx_mix
  import audio_fx_pkg::*;
#(
  parameter int unsigned W = 12
) (
  input  logic signed [W-1:0]          cur_i,
  input  logic [FX_TAPS-1:0][W-1:0]    tap_i,
  input  fx_sel_e                      sel_i,
  output logic signed [W-1:0]          mix_o
);

  localparam logic signed [W:0]   SAT_HI = {2'b00, {(W-1){1'b1}}};
  localparam logic signed [W:0]   SAT_LO = {2'b11, {(W-1){1'b0}}};

  logic signed [W-1:0] cand [FX_NUM];

  for (genvar g = 0; g < FX_NUM; g++) begin : g_fx
    localparam int unsigned TAP = fx_tap(g);
    localparam bit          SUB = (g == 3);
    logic signed [W-1:0] half;
    logic signed [W:0]   raw;

    assign half = $signed(tap_i[TAP]) >>> 1;
    if (SUB) begin : g_sub
      assign raw = $signed({cur_i[W-1], cur_i}) - $signed({half[W-1], half});
    end else begin : g_add
      assign raw = $signed({cur_i[W-1], cur_i}) + $signed({half[W-1], half});
    end

    always_comb begin
      if (raw > SAT_HI)      cand[g] = SAT_HI[W-1:0];
      else if (raw < SAT_LO) cand[g] = SAT_LO[W-1:0];
      else                   cand[g] = raw[W-1:0];
    end
  end

  always_comb begin
    case (sel_i)
      FX_ECHO:   mix_o = cand[0];
      FX_CHORUS: mix_o = cand[1];
      FX_FLANGE: mix_o = cand[2];
      default:   mix_o = cand[3];
    endcase
  end

endmodule

// File: rtl/audio_fx_delay.sv
module audio_fx_delay
  import audio_fx_pkg::*;
#(
  parameter int unsigned SAMPLE_W   = 12,
  parameter int unsigned DEPTH      = 4096,
  parameter int unsigned ECHO_D     = 2048,
  parameter int unsigned SWEEP_MIN  = 1,
  parameter int unsigned CHORUS_MAX = 801,
  parameter int unsigned FLANGE_MAX = 400,
  parameter int unsigned SWEEP_DIV  = 16
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       strobe_i,
  input  logic signed [SAMPLE_W-1:0] sample_i,
  input  logic [1:0]                 sel_i,
  output logic signed [SAMPLE_W-1:0] sample_o,
  output logic                       valid_o
);

  localparam int unsigned ADDR_W = $clog2(DEPTH);
  localparam int unsigned PRE_W  = (SWEEP_DIV > 1) ? $clog2(SWEEP_DIV) : 1;

  logic [ADDR_W-1:0] wr_ptr;
  logic [PRE_W-1:0]  pre_q;
  logic              step_en;
  logic [ADDR_W-1:0] chorus_d, flange_d;

  logic [FX_TAPS-1:0][ADDR_W-1:0]   rd_addr;
  logic [FX_TAPS-1:0][SAMPLE_W-1:0] tap_q;

  logic signed [SAMPLE_W-1:0] cur_q;
  fx_sel_e                    sel_q;
  logic                       s1_vld_q;
  logic signed [SAMPLE_W-1:0] mix_d;
  logic signed [SAMPLE_W-1:0] out_q;
  logic                       vld_q;

  assign step_en = strobe_i && (pre_q == PRE_W'(SWEEP_DIV - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr <= '0;
      pre_q  <= '0;
    end else if (strobe_i) begin
      wr_ptr <= wr_ptr + 1'b1;
      pre_q  <= step_en ? '0 : pre_q + 1'b1;
    end
  end

  sweep_gen #(
    .D_W  (ADDR_W),
    .MIN_D(SWEEP_MIN),
    .MAX_D(CHORUS_MAX)
  ) u_sweep_chorus (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .step_i (step_en),
    .delay_o(chorus_d)
  );

  sweep_gen #(
    .D_W  (ADDR_W),
    .MIN_D(SWEEP_MIN),
    .MAX_D(FLANGE_MAX)
  ) u_sweep_flange (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .step_i (step_en),
    .delay_o(flange_d)
  );

  // taps count back from the slot being written this strobe
  assign rd_addr[0] = wr_ptr - ADDR_W'(ECHO_D);
  assign rd_addr[1] = wr_ptr - chorus_d;
  assign rd_addr[2] = wr_ptr - flange_d;

  delay_ram #(
    .DATA_W(SAMPLE_W),
    .DEPTH (DEPTH),
    .N_RD  (FX_TAPS)
  ) u_ram (
    .clk_i    (clk_i),
    .wr_en_i  (strobe_i),
    .wr_addr_i(wr_ptr),
    .wr_data_i(sample_i),
    .rd_en_i  (strobe_i),
    .rd_addr_i(rd_addr),
    .rd_data_o(tap_q)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cur_q    <= '0;
      sel_q    <= FX_ECHO;
      s1_vld_q <= 1'b0;
    end else begin
      s1_vld_q <= strobe_i;
      if (strobe_i) begin
        cur_q <= sample_i;
        sel_q <= fx_sel_e'(sel_i);
      end
    end
  end

  fx_mix #(
    .W(SAMPLE_W)
  ) u_mix (
    .cur_i(cur_q),
    .tap_i(tap_q),
    .sel_i(sel_q),
    .mix_o(mix_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_q <= '0;
      vld_q <= 1'b0;
    end else begin
      vld_q <= s1_vld_q;
      if (s1_vld_q) out_q <= mix_d;
    end
  end

  assign sample_o = out_q;
  assign valid_o  = vld_q;

endmodule

// File: rtl/audio_fx_delay_chk.sv
module audio_fx_delay_chk #(
  parameter int unsigned ADDR_W     = 12,
  parameter int unsigned SAMPLE_W   = 12,
  parameter int unsigned SWEEP_MIN  = 1,
  parameter int unsigned CHORUS_MAX = 801,
  parameter int unsigned FLANGE_MAX = 400
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                strobe_i,
  input logic                valid_o,
  input logic [SAMPLE_W-1:0] sample_o,
  input logic [ADDR_W-1:0]   wr_ptr,
  input logic [ADDR_W-1:0]   chorus_d,
  input logic [ADDR_W-1:0]   flange_d
);

  AST_VALID_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strobe_i |=> ##1 valid_o); // R2
  AST_VALID_SOURCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> $past(strobe_i, 2)); // R2
  AST_OUT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> $stable(sample_o)); // R3
  AST_PTR_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strobe_i |=> wr_ptr == ADDR_W'($past(wr_ptr) + 1'b1)); // R4
  AST_PTR_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !strobe_i |=> $stable(wr_ptr)); // R4
  AST_CHORUS_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chorus_d >= ADDR_W'(SWEEP_MIN) && chorus_d <= ADDR_W'(CHORUS_MAX)); // R6
  AST_FLANGE_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flange_d >= ADDR_W'(SWEEP_MIN) && flange_d <= ADDR_W'(FLANGE_MAX)); // R7
  AST_CHORUS_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !strobe_i |=> $stable(chorus_d)); // R9
  AST_FLANGE_SLEW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strobe_i |=> (flange_d == $past(flange_d)) ||
                 (flange_d == ADDR_W'($past(flange_d) + 1'b1)) ||
                 (flange_d == ADDR_W'($past(flange_d) - 1'b1))); // R9

endmodule

bind audio_fx_delay audio_fx_delay_chk #(
  .ADDR_W    (ADDR_W),
  .SAMPLE_W  (SAMPLE_W),
  .SWEEP_MIN (SWEEP_MIN),
  .CHORUS_MAX(CHORUS_MAX),
  .FLANGE_MAX(FLANGE_MAX)
) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .strobe_i(strobe_i),
  .valid_o (valid_o),
  .sample_o(sample_o),
  .wr_ptr  (wr_ptr),
  .chorus_d(chorus_d),
  .flange_d(flange_d)
);

// File: tb/audio_fx_delay_bench.sv
module audio_fx_delay_bench;

  localparam int N_STROBES = 13600;
  localparam int WATCHDOG  = 150000;

  typedef struct {
    bit    care;
    int    exp;
    string tag;
  } item_t;

  logic              clk = 1'b0;
  logic              rst_ni = 1'b0;
  logic              strobe = 1'b0;
  logic signed [11:0] sample = '0;
  logic [1:0]        sel = '0;
  logic signed [11:0] sample_o;
  logic              valid_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  bit mon_on = 1'b0;

  item_t sb_q[$];
  logic signed [11:0] hist [16384];
  int n = 0;
  int c_d = 1, f_d = 1, pre = 0;
  bit c_up = 1'b1, f_up = 1'b1;
  logic [1:0] pipe = '0;
  int last_out = 0;
  int unsigned seed = 32'h1234_5678;

  always #5 clk = ~clk;

  audio_fx_delay u_audio_fx_delay (
    .clk_i   (clk),
    .rst_ni  (rst_ni),
    .strobe_i(strobe),
    .sample_i(sample),
    .sel_i   (sel),
    .sample_o(sample_o),
    .valid_o (valid_o)
  );

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) pipe <= '0;
    else         pipe <= {pipe[0], strobe};
  end

  function automatic int clamp(input int v);
    if (v > 2047)  return 2047;
    if (v < -2048) return -2048;
    return v;
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic sweep_step(inout int d, inout bit up, input int mx);
    if (up) begin
      if (d == mx) begin up = 1'b0; d = d - 1; end
      else d = d + 1;
    end else begin
      if (d == 1) begin up = 1'b1; d = d + 1; end
      else d = d - 1;
    end
  endtask

  // called at a falling edge; leaves the bench at a falling edge
  task automatic drive(input int x, input int s, input int gap);
    item_t it;
    int d, y, raw;
    bit sub;
    strobe = 1'b1;
    sample = x[11:0];
    sel    = s[1:0];
    case (s)
      0:       begin d = 2048; it.tag = (n >= 4096) ? "R4 R5" : "R5"; end
      1:       begin d = c_d;  it.tag = "R6 R9"; end
      2:       begin d = f_d;  it.tag = "R7 R9"; end
      default: begin d = f_d;  it.tag = "R8"; end
    endcase
    sub = (s == 3);
    it.care = (n - d) >= 0;
    y = it.care ? int'(hist[n - d]) : 0;
    raw = sub ? x - (y >>> 1) : x + (y >>> 1);
    if (raw != clamp(raw)) it.tag = {it.tag, " R10"};
    it.exp = clamp(raw);
    sb_q.push_back(it);
    hist[n] = x[11:0];
    n++;
    pre++;
    if (pre == 16) begin
      pre = 0;
      sweep_step(c_d, c_up, 801);
      sweep_step(f_d, f_up, 400);
    end
    @(negedge clk);
    strobe = 1'b0;
    sel    = ~s[1:0];            // R11: select moves between strobes
    sample = ~x[11:0];
    repeat (gap) @(negedge clk);
  endtask

  // monitor: scoreboard pop on valid, hold check otherwise
  initial begin
    item_t it;
    forever begin
      @(negedge clk);
      if (mon_on && !done) begin
        check(valid_o === pipe[1], "R2 valid timing", int'(valid_o), int'(pipe[1]));
        if (valid_o === 1'b1) begin
          if (sb_q.size() == 0) begin
            check(1'b0, "R2 unexpected result", int'(sample_o), 0);
          end else begin
            it = sb_q.pop_front();
            if (it.care)
              check(int'(sample_o) == it.exp, it.tag, int'(sample_o), it.exp);
          end
          last_out = int'(sample_o);
        end else begin
          check(int'(sample_o) == last_out, "R3 R11 hold", int'(sample_o), last_out);
        end
      end
    end
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      errors++;
      $display("FAIL R2 watchdog actual running expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int x, s, gap;
    repeat (3) @(negedge clk);
    check(sample_o == 0, "R1 sample_o in reset", int'(sample_o), 0);
    check(valid_o == 1'b0, "R1 valid_o in reset", int'(valid_o), 0);
    rst_ni = 1'b1;
    @(negedge clk);
    check(sample_o == 0 && valid_o == 1'b0, "R1 after release", int'(sample_o), 0);
    mon_on = 1'b1;
    for (int i = 0; i < N_STROBES; i++) begin
      if (i < 3000 || i >= 7000) begin
        seed = seed * 32'd1103515245 + 32'd12345;
        x = int'((seed >> 16) & 32'hFFF) - 2048;
      end else if (i < 6000) begin
        x = ((i * 7) % 4096) - 2048;
      end else begin
        x = ((i / 5) % 2 == 0) ? 2047 : -2048;
      end
      s   = (i / 37) % 4;
      gap = (i % 5 == 0) ? 0 : (i % 3) + 1;
      drive(x, s, gap);
    end
    repeat (6) @(negedge clk);
    check(sb_q.size() == 0, "R2 all results delivered", sb_q.size(), 0);
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule